// File: doc/BRIEF.md
# Command Ring Fetch Engine

This block sits on the controller side of an outbound command ring. Host software stores 32-bit command words in a ring of 256 slots in system memory, programs the ring base, and then moves a write pointer forward. While the engine is running, it compares its own read pointer with that write pointer. For each pending slot it advances the read pointer, reads the slot through a simple memory read port, and presents the word on an output stream with a valid/ready handshake. The stream also carries the codec address taken from the top nibble of the word.

Software owns the write pointer and the ring base. The hardware read pointer can only be brought back to zero through a two-step handshake. Software first sets a reset bit and the engine acknowledges it. Software then clears the bit and the pointer reads zero. When software clears the run bit, no new fetch starts, but the run bit keeps reading as set until the entry already in flight has left the engine.

Top module: `cmd_ring_fetch`

## Requirements
- R1: After reset every register reads 0, `cmd_valid` is 0 and `mem_rd_en` is 0.
- R2: Register offsets on `reg_addr`: 0 holds base address bits 31:0, 1 holds base bits 63:32, 2 holds the write pointer in bits 7:0, 3 holds the read pointer in bits 7:0 and the reset bit in bit 15, 4 holds the size code in bits 1:0, and 5 is control with the run bit in bit 1. The base and size registers read back what was written.
- R3: A write to offset 3 with bit 15 set forces the read pointer to 0 on the next cycle. Offset 3 then reads 0x8000 until software clears the bit, and no fetch starts while the reset is pending.
- R4: A write to offset 3 with bit 15 clear ends a pending reset. The register then reads 0, and fetching resumes: slot 1 is the next slot read.
- R5: While run is set, the size code is 2, no reset is pending and the read pointer differs from the write pointer, the engine increments the read pointer. It then reads the new slot at byte address base + 4 × slot. The pointer wraps from 255 to 0.
- R6: The engine has at most one memory read outstanding. The word read from memory appears on `cmd_valid`/`cmd_word` on the cycle after the read data returns.
- R7: `cmd_codec` equals bits 31:28 of the presented command word.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_word` stays unchanged.
- R9: After software clears the run bit, no new fetch starts. Bit 1 of offset 5 keeps reading 1 until the entry in flight has been accepted, and then reads 0.
- R10: While the size code is not 2, no fetch starts and the read pointer holds.
- R11: A write pointer value becomes visible to the fetch logic one cycle after it is written. A write to offset 3 with bit 15 clear never changes the read pointer.
- R12: Ring entries are little-endian: byte lane 0 of `mem_rd_data` (bits 7:0) is the least significant byte of the command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | 64 | Byte address of the slot being read |
| mem_rd_data | input | 32 | Read data, one cycle after the request |
| cmd_valid | output | 1 | Command word available |
| cmd_ready | input | 1 | Consumer accepts the command word |
| cmd_word | output | 32 | Command word |
| cmd_codec | output | 4 | Codec address of the command |

## Verification
The assertions check four things on every cycle. The pointer acknowledges a reset request and stays at zero while the reset is pending. It advances by exactly one with wrap whenever a fetch starts. Only one memory read is ever in flight, and a held word stays put under back-pressure. The bench scenarios cover the behaviour that only shows over a whole sequence. These are the order and content of the fetched words against memory, the drain of the run bit after a stop, gating by the size code, the one-cycle latency of write-pointer updates, and pointer writes that must be ignored.

// File: rtl/cmd_ring_pkg.sv
package cmd_ring_pkg;

   typedef enum logic [2:0] {
      REG_BASE_LO = 3'd0,
      REG_BASE_HI = 3'd1,
      REG_WPTR    = 3'd2,
      REG_RPTR    = 3'd3,
      REG_SIZE    = 3'd4,
      REG_CTRL    = 3'd5
   } reg_sel_e;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_WAIT = 2'd1,
      FS_HOLD = 2'd2
   } fetch_state_e;

endpackage

// File: rtl/cmd_ring_regs.sv
module cmd_ring_regs
   import cmd_ring_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int PTR_W   = 8,
   parameter int SIZE_W  = 2,
   parameter int RUN_BIT = 1,
   parameter int RST_BIT = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [PTR_W-1:0]  rp_i,
   input  logic              rst_ack_i,
   input  logic              busy_i,
   output logic [ADDR_W-1:0] base_o,
   output logic [PTR_W-1:0]  wp_o,
   output logic [SIZE_W-1:0] size_o,
   output logic              run_o,
   output logic              rp_wr_o,
   output logic              rp_rst_o
);

   localparam int HI_W = ADDR_W - 32;

   if (ADDR_W <= 32 || ADDR_W > 64) begin : g_bad_addr
      $error("cmd_ring_regs: ADDR_W must be in 33..64");
   end
   if (PTR_W < 1 || PTR_W >= RST_BIT || RST_BIT > 31) begin : g_bad_ptr
      $error("cmd_ring_regs: PTR_W must fit below RST_BIT");
   end
   if (RUN_BIT < 0 || RUN_BIT > 31 || SIZE_W < 1 || SIZE_W > 8) begin : g_bad_ctl
      $error("cmd_ring_regs: control or size field out of range");
   end

   logic [ADDR_W-1:0] base_q;
   logic [PTR_W-1:0]  wp_q;
   logic [SIZE_W-1:0] size_q;
   logic              run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         wp_q   <= '0;
         size_q <= '0;
         run_q  <= 1'b0;
      end else if (reg_wr) begin
         case (reg_sel_e'(reg_addr))
            REG_BASE_LO: base_q[31:0]       <= reg_wdata;
            REG_BASE_HI: base_q[ADDR_W-1:32] <= reg_wdata[HI_W-1:0];
            REG_WPTR:    wp_q               <= reg_wdata[PTR_W-1:0];
            REG_SIZE:    size_q             <= reg_wdata[SIZE_W-1:0];
            REG_CTRL:    run_q              <= reg_wdata[RUN_BIT];
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_sel_e'(reg_addr))
         REG_BASE_LO: reg_rdata = base_q[31:0];
         REG_BASE_HI: reg_rdata[HI_W-1:0] = base_q[ADDR_W-1:32];
         REG_WPTR:    reg_rdata[PTR_W-1:0] = wp_q;
         REG_RPTR: begin
            reg_rdata[PTR_W-1:0] = rp_i;
            reg_rdata[RST_BIT]   = rst_ack_i;
         end
         REG_SIZE:    reg_rdata[SIZE_W-1:0] = size_q;
         REG_CTRL:    reg_rdata[RUN_BIT] = run_q | busy_i;
         default: ;
      endcase
   end

   assign base_o   = base_q;
   assign wp_o     = wp_q;
   assign size_o   = size_q;
   assign run_o    = run_q;
   assign rp_wr_o  = reg_wr && (reg_sel_e'(reg_addr) == REG_RPTR);
   assign rp_rst_o = reg_wdata[RST_BIT];

endmodule

// File: rtl/cmd_ring_ptr.sv
module cmd_ring_ptr #(
   parameter int PTR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rp_wr,
   input  logic             rp_rst,
   input  logic             adv,
   output logic [PTR_W-1:0] rp,
   output logic             rst_pend
);

   if (PTR_W < 1) begin : g_bad_w
      $error("cmd_ring_ptr: PTR_W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rp <= '0;
      end else if (rp_wr && rp_rst) begin
         rp <= '0;
      end else if (adv) begin
         rp <= rp + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_pend <= 1'b0;
      end else if (rp_wr) begin
         rst_pend <= rp_rst;
      end
   end

   // R3: a reset request is acknowledged and the pointer reads zero next cycle
   assert_reset_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rp_wr && rp_rst) |=> (rst_pend && rp == '0));

   // R3: while a reset is pending the fetch side never moves the pointer
   assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_pend && !rp_wr) |=> (rp == '0));

   // R5: every fetch start moves the pointer forward by exactly one, with wrap
   assert_advance_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !(rp_wr && rp_rst)) |=> (rp == $past(rp) + 1'b1));

endmodule

// File: rtl/cmd_ring_fetch_fsm.sv
module cmd_ring_fetch_fsm
   import cmd_ring_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int DATA_W    = 32,
   parameter int PTR_W     = 8,
   parameter int SIZE_W    = 2,
   parameter int SIZE_CODE = 2,
   parameter int CODEC_W   = 4,
   parameter bit BYTE_SWAP = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic               rst_pend,
   input  logic [SIZE_W-1:0]  size,
   input  logic [PTR_W-1:0]   rp,
   input  logic [PTR_W-1:0]   wp,
   input  logic [ADDR_W-1:0]  base,
   output logic               adv,
   output logic               busy,
   output logic               mem_rd_en,
   output logic [ADDR_W-1:0]  mem_rd_addr,
   input  logic [DATA_W-1:0]  mem_rd_data,
   output logic               cmd_valid,
   input  logic               cmd_ready,
   output logic [DATA_W-1:0]  cmd_word,
   output logic [CODEC_W-1:0] cmd_codec
);

   localparam int NBYTES  = DATA_W / 8;
   localparam int BYTE_SH = $clog2(NBYTES);
   localparam logic [SIZE_W-1:0] SIZE_SEL = SIZE_W'(SIZE_CODE);

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
      $error("cmd_ring_fetch_fsm: DATA_W must be a whole number of bytes");
   end
   if (CODEC_W < 1 || CODEC_W > DATA_W) begin : g_bad_codec
      $error("cmd_ring_fetch_fsm: CODEC_W out of range");
   end
   if (PTR_W + BYTE_SH > ADDR_W) begin : g_bad_span
      $error("cmd_ring_fetch_fsm: ring does not fit the address width");
   end

   fetch_state_e      state_q;
   logic [DATA_W-1:0] word_q;
   logic [DATA_W-1:0] word_in;
   logic [PTR_W-1:0]  slot;
   logic              go;

   if (BYTE_SWAP) begin : g_swap
      for (genvar b = 0; b < NBYTES; b++) begin : g_lane
         assign word_in[b*8 +: 8] = mem_rd_data[(NBYTES-1-b)*8 +: 8];
      end
   end else begin : g_le
      assign word_in = mem_rd_data;
   end

   assign slot = rp + 1'b1;
   assign go   = (state_q == FS_IDLE) && run && !rst_pend &&
                 (size == SIZE_SEL) && (rp != wp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         word_q  <= '0;
      end else begin
         case (state_q)
            FS_IDLE: if (go) state_q <= FS_WAIT;
            FS_WAIT: begin
               word_q  <= word_in;
               state_q <= FS_HOLD;
            end
            FS_HOLD: if (cmd_ready) state_q <= FS_IDLE;
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   assign adv         = go;
   assign busy        = (state_q != FS_IDLE);
   assign mem_rd_en   = go;
   assign mem_rd_addr = base + ADDR_W'({slot, {BYTE_SH{1'b0}}});
   assign cmd_valid   = (state_q == FS_HOLD);
   assign cmd_word    = word_q;
   assign cmd_codec   = word_q[DATA_W-1 -: CODEC_W];

   // R6: a new read is never issued while one is outstanding
   assert_single_outstanding_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> !mem_rd_en);

   // R8: a word refused by the consumer stays presented and unchanged
   assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_word)));

   // R6: data returned by memory is presented on the following cycle
   assert_present_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |=> ##1 cmd_valid);

endmodule

// File: rtl/cmd_ring_fetch.sv
module cmd_ring_fetch #(
   parameter int ADDR_W    = 64,
   parameter int DATA_W    = 32,
   parameter int PTR_W     = 8,
   parameter int SIZE_W    = 2,
   parameter int SIZE_CODE = 2,
   parameter int CODEC_W   = 4,
   parameter int RUN_BIT   = 1,
   parameter int RST_BIT   = 15,
   parameter bit BYTE_SWAP = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic [2:0]         reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               mem_rd_en,
   output logic [ADDR_W-1:0]  mem_rd_addr,
   input  logic [DATA_W-1:0]  mem_rd_data,
   output logic               cmd_valid,
   input  logic               cmd_ready,
   output logic [DATA_W-1:0]  cmd_word,
   output logic [CODEC_W-1:0] cmd_codec
);

   logic [ADDR_W-1:0] base;
   logic [PTR_W-1:0]  wp;
   logic [PTR_W-1:0]  rp;
   logic [SIZE_W-1:0] size;
   logic              run;
   logic              rp_wr;
   logic              rp_rst;
   logic              rst_pend;
   logic              adv;
   logic              busy;

   cmd_ring_regs #(
      .ADDR_W (ADDR_W),
      .PTR_W  (PTR_W),
      .SIZE_W (SIZE_W),
      .RUN_BIT(RUN_BIT),
      .RST_BIT(RST_BIT)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .rp_i     (rp),
      .rst_ack_i(rst_pend),
      .busy_i   (busy),
      .base_o   (base),
      .wp_o     (wp),
      .size_o   (size),
      .run_o    (run),
      .rp_wr_o  (rp_wr),
      .rp_rst_o (rp_rst)
   );

   cmd_ring_ptr #(
      .PTR_W(PTR_W)
   ) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .rp_wr   (rp_wr),
      .rp_rst  (rp_rst),
      .adv     (adv),
      .rp      (rp),
      .rst_pend(rst_pend)
   );

   cmd_ring_fetch_fsm #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .PTR_W    (PTR_W),
      .SIZE_W   (SIZE_W),
      .SIZE_CODE(SIZE_CODE),
      .CODEC_W  (CODEC_W),
      .BYTE_SWAP(BYTE_SWAP)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .rst_pend   (rst_pend),
      .size       (size),
      .rp         (rp),
      .wp         (wp),
      .base       (base),
      .adv        (adv),
      .busy       (busy),
      .mem_rd_en  (mem_rd_en),
      .mem_rd_addr(mem_rd_addr),
      .mem_rd_data(mem_rd_data),
      .cmd_valid  (cmd_valid),
      .cmd_ready  (cmd_ready),
      .cmd_word   (cmd_word),
      .cmd_codec  (cmd_codec)
   );

   // R9: the run bit reads set whenever an entry is still in flight
   assert_run_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && reg_addr == 3'd5) |-> reg_rdata[RUN_BIT]);

endmodule

// File: tb/cmd_ring_fetch_test.sv
`timescale 1ns/1ps
module cmd_ring_fetch_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr;
   logic [2:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        mem_rd_en;
   logic [63:0] mem_rd_addr;
   logic [31:0] mem_rd_data;
   logic        cmd_valid;
   logic        cmd_ready;
   logic [31:0] cmd_word;
   logic [3:0]  cmd_codec;

   always #10 clk = ~clk;

   cmd_ring_fetch uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_en(mem_rd_en),
      .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
      .cmd_codec(cmd_codec)
   );

   localparam logic [63:0] BASE = 64'h0000_0001_0000_1000;

   logic [31:0] mem [256];
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // synchronous memory, one cycle of latency
   always @(posedge clk) begin
      if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[9:2]];
   end

   // behavioural reference model
   logic [63:0] m_base;
   logic [7:0]  m_rp, m_wp, m_slot;
   logic [1:0]  m_size;
   logic        m_run, m_pend, m_valid;
   logic [31:0] m_word;
   int          m_state;
   logic        m_go;

   assign m_go = (m_state == 0) && m_run && !m_pend && (m_size == 2'd2) && (m_rp != m_wp);

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_base = '0; m_rp = '0; m_wp = '0; m_slot = '0; m_size = '0;
         m_run = 1'b0; m_pend = 1'b0; m_valid = 1'b0; m_word = '0; m_state = 0;
      end else begin
         automatic logic start = m_go;
         if (m_state == 1) begin
            m_word = mem[m_slot]; m_valid = 1'b1; m_state = 2;
         end else if (m_state == 2 && cmd_ready) begin
            m_valid = 1'b0; m_state = 0;
         end
         if (start) begin
            m_rp = m_rp + 8'd1; m_slot = m_rp; m_state = 1;
         end
         if (reg_wr) begin
            case (reg_addr)
               3'd0: m_base[31:0] = reg_wdata;
               3'd1: m_base[63:32] = reg_wdata;
               3'd2: m_wp = reg_wdata[7:0];
               3'd3: begin
                  if (reg_wdata[15]) begin m_rp = 8'd0; m_pend = 1'b1; end
                  else m_pend = 1'b0;
               end
               3'd4: m_size = reg_wdata[1:0];
               3'd5: m_run = reg_wdata[1];
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(cmd_valid === m_valid, "R6 valid", 64'(cmd_valid), 64'(m_valid));
         if (m_valid) begin
            chk(cmd_word === m_word, "R12 word", 64'(cmd_word), 64'(m_word));
            chk(cmd_codec === m_word[31:28], "R7 codec", 64'(cmd_codec), 64'(m_word[31:28]));
         end
         chk(mem_rd_en === m_go, "R5 read enable", 64'(mem_rd_en), 64'(m_go));
         if (m_go)
            chk(mem_rd_addr === m_base + {54'd0, 8'(m_rp + 8'd1), 2'b00}, "R5 address",
                mem_rd_addr, m_base + {54'd0, 8'(m_rp + 8'd1), 2'b00});
      end
   end

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
      reg_addr = a;
      #1;
      chk(reg_rdata === exp, req, 64'(reg_rdata), 64'(exp));
   endtask

   task automatic drain();
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (m_state == 0 && (m_rp == m_wp || !m_run) && !cmd_valid) break;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++)
         mem[i] = {4'(i), 4'hA, 8'(i), 8'(~i), 8'(i * 3)};
      rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; cmd_ready = 1'b1;
      mem_rd_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int a = 0; a < 6; a++) rd(3'(a), 32'd0, "R1 register reset");
      chk(cmd_valid === 1'b0, "R1 valid", 64'(cmd_valid), 0);
      chk(mem_rd_en === 1'b0, "R1 read", 64'(mem_rd_en), 0);

      // R2: base and size readback
      wr(3'd0, BASE[31:0]);
      wr(3'd1, BASE[63:32]);
      wr(3'd4, 32'd2);
      rd(3'd0, BASE[31:0], "R2 base low");
      rd(3'd1, BASE[63:32], "R2 base high");
      rd(3'd4, 32'd2, "R2 size");

      // R11: write pointer effect is one cycle after the write
      wr(3'd5, 32'h2);
      chk(mem_rd_en === 1'b0, "R11 no fetch before wp", 64'(mem_rd_en), 0);
      wr(3'd2, 32'd3);
      chk(mem_rd_en === 1'b1, "R11 wp seen next cycle", 64'(mem_rd_en), 1);
      chk(mem_rd_addr === BASE + 64'd4, "R5 first slot address", mem_rd_addr, BASE + 64'd4);
      drain();
      rd(3'd3, 32'd3, "R5 pointer after three entries");

      // R8: back-pressure
      cmd_ready = 1'b0;
      wr(3'd2, 32'd5);
      repeat (8) @(negedge clk);
      chk(cmd_valid === 1'b1 && cmd_word === mem[4], "R8 held word", 64'(cmd_word), 64'(mem[4]));
      cmd_ready = 1'b1;
      drain();
      rd(3'd3, 32'd5, "R5 pointer after back-pressure");

      // R9: stop drains the entry in flight
      cmd_ready = 1'b0;
      wr(3'd2, 32'd8);
      for (int i = 0; i < 10 && !cmd_valid; i++) @(negedge clk);
      wr(3'd5, 32'h0);
      rd(3'd5, 32'h2, "R9 run still reads set");
      cmd_ready = 1'b1;
      repeat (4) @(negedge clk);
      rd(3'd5, 32'h0, "R9 run reads clear after drain");
      repeat (6) @(negedge clk);
      chk(cmd_valid === 1'b0, "R9 no new fetch", 64'(cmd_valid), 0);
      rd(3'd3, 32'd6, "R9 pointer stopped");

      // R3 / R4: pointer reset handshake
      wr(3'd3, 32'h8000);
      rd(3'd3, 32'h8000, "R3 reset acknowledged");
      wr(3'd5, 32'h2);
      repeat (10) @(negedge clk);
      chk(cmd_valid === 1'b0, "R3 no fetch while pending", 64'(cmd_valid), 0);
      rd(3'd3, 32'h8000, "R3 still pending");
      wr(3'd3, 32'h0);
      rd(3'd3, 32'h0, "R4 pointer reads zero");
      chk(mem_rd_addr === BASE + 64'd4 && mem_rd_en, "R4 resumes at slot 1", mem_rd_addr, BASE + 64'd4);
      drain();
      rd(3'd3, 32'd8, "R4 pointer after resume");

      // R11: pointer write without reset bit is ignored
      wr(3'd3, 32'h0033);
      rd(3'd3, 32'd8, "R11 pointer unchanged");

      // R10: size gating
      wr(3'd4, 32'd1);
      wr(3'd2, 32'd10);
      repeat (10) @(negedge clk);
      chk(cmd_valid === 1'b0, "R10 no fetch", 64'(cmd_valid), 0);
      rd(3'd3, 32'd8, "R10 pointer holds");
      wr(3'd4, 32'd2);
      drain();
      rd(3'd3, 32'd10, "R10 resumes with size 2");

      // R5: wrap from 255 to 0
      wr(3'd3, 32'h8000);
      wr(3'd2, 32'd253);
      wr(3'd3, 32'h0);
      drain();
      rd(3'd3, 32'd253, "R5 pointer before wrap");
      wr(3'd2, 32'd2);
      drain();
      rd(3'd3, 32'd2, "R5 pointer after wrap");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule